// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Model

A synthesizable behavioural model of a synchronous SRAM with independent read and write data ports. Data moves on both halves of the input clock. Every access is a four-word burst whose base address is taken on the rising edge of K.

The model runs on a double-rate clock `clk2x`: each tick is one half-cycle. The input `k_rise` is high on the ticks that stand for K rising edges and low on the ticks that stand for K-bar rising edges. The two ticks alternate, and the first tick after reset is a K tick.

A write command takes its four data words and their byte-lane enables on the four half-cycles of the next two K cycles. A read command returns its four words after two and a half cycles, with a valid flag and an output-enable flag. The read and write ports are independent, so one read and one write may start on the same K rise. A strobe held low for two K rises in a row is honoured only once.

Top module: `qdr_b4_sram`

## Requirements
- R1: Commands and the address are captured only on ticks with `k_rise`=1. Selects and address presented on ticks with `k_rise`=0 start nothing.
- R2: A write accepted on tick T stores word i (i=0..3), taken from `d` on tick T+2+i, at word location {addr, i}. The 2-bit burst index is the low bits of the word location.
- R3: A read accepted on tick T presents the contents of {addr, i} on `q` after tick T+5+i, for i=0..3, with `q_valid`=1 and `q_oe`=1. The first word therefore follows a K-bar edge and the last follows a K edge.
- R4: If a select strobe started an operation on the previous K tick, the same strobe being low on the current K tick is ignored. The second request is dropped, and a third consecutive low K tick is accepted again.
- R5: When no read word is due, `q`=0, `q_valid`=0 and `q_oe`=0. `d` and `lane_wr_n` are ignored on ticks that carry no write word, even with both lanes enabled.
- R6: `lane_wr_n[0]`=0 writes `d[8:0]` and `lane_wr_n[1]`=0 writes `d[17:9]`. A lane whose enable is 1 keeps its old contents, so both enables at 1 write nothing.
- R7: The lane enables are sampled separately with each of the four write words, and each word uses its own pair of enables.
- R8: While `rst_n`=0 and after it is released, with no read in flight, `q`, `q_valid` and `q_oe` are 0. A reset during a read burst cancels it.
- R9: The ports are independent, and a read and a write may both be accepted on one K tick. Each read word returns the contents stored by write words on earlier ticks. A write to the same burst accepted two K ticks after the read therefore leaves the read returning the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; one rising edge per half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| k_rise | input | 1 | High on ticks that are K rising edges, low on K-bar ticks |
| rd_sel_n | input | 1 | Active-low read select |
| wr_sel_n | input | 1 | Active-low write select |
| addr | input | ADDR_W | Burst base address |
| d | input | 18 | Write data word |
| lane_wr_n | input | 2 | Active-low byte-lane write enables |
| q | output | 18 | Read data word |
| q_valid | output | 1 | High while `q` carries a burst word |
| q_oe | output | 1 | Output drive enable; low means high impedance |

## Verification
The bench holds selects low on two K ticks in a row for both reads and writes. A model that accepted the repeat would emit extra read words into idle ticks or overwrite a burst with the dropped write's data. It pulls selects low on K-bar ticks, where a model without the phase qualification would start stray bursts. It varies the lane enables from word to word, which exposes a model that latches one enable pair per burst or swaps lanes. It also issues a read followed two K ticks later by a write to the same burst, and a read and a write on the same K tick. A model with the wrong read or write latency returns old data where new is due, or new where old is due, on a specific word.

// File: rtl/qdr_b4_pkg.sv
// Package: shared constants and types of the burst-of-four SRAM model.
// Assumes an 18-bit word made of two 9-bit lanes and tick-granular timing.
package qdr_b4_pkg;
    localparam int WORD_W    = 18;
    localparam int LANE_W    = 9;
    localparam int LANES     = WORD_W / LANE_W;
    localparam int BURST_LEN = 4;
    localparam int IDX_W     = $clog2(BURST_LEN);
    // Ticks from the accepting K edge to the edge that moves word 0.
    localparam int WR_LAG    = 2;
    localparam int RD_LAG    = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_en_t;
endpackage

// File: rtl/qdr_b4_cmd_gate.sv
// Module: accepts one select strobe on K ticks. It drops a request
// that directly follows an accepted one of the same kind.
// Assumes k_rise alternates and reset leaves the next tick a K tick.
module qdr_b4_cmd_gate (
    input  logic clk2x,
    input  logic rst_n,
    input  logic k_rise,
    input  logic sel_n,
    output logic go
);
    logic took_last;

    // Accept only on K ticks, and only if the previous K tick took nothing.
    assign go = k_rise & ~sel_n & ~took_last;

    // Remember whether the most recent K tick started an operation.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            took_last <= 1'b0;
        end else if (k_rise) begin
            took_last <= go;
        end
    end
endmodule

// File: rtl/qdr_b4_burst_pipe.sv
// Module: delays an accepted command by LAG ticks and then walks its
// four burst words, one per tick. Gives the word address due this tick.
// Assumes commands are at least BURST_LEN ticks apart, so at most one
// burst is in its word window at a time.
module qdr_b4_burst_pipe
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LAG    = 2
) (
    input  logic                    clk2x,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [ADDR_W-1:0]       base,
    output logic                    act,
    output logic [ADDR_W+IDX_W-1:0] word_addr
);
    localparam int DEPTH = LAG + BURST_LEN - 1;
    localparam int WA_W  = ADDR_W + IDX_W;

    logic [DEPTH-1:0]  slot_v;
    logic [ADDR_W-1:0] slot_a [DEPTH];
    logic [BURST_LEN-1:0] hit;
    logic [WA_W-1:0]   cand [BURST_LEN];

    // Shift the accept flags; slot j holds the command from j+1 ticks ago.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            slot_v <= '0;
        end else begin
            slot_v <= {slot_v[DEPTH-2:0], go};
        end
    end

    // Shift the captured base addresses alongside the flags.
    always_ff @(posedge clk2x) begin
        slot_a[0] <= base;
        for (int j = 1; j < DEPTH; j++) begin
            slot_a[j] <= slot_a[j-1];
        end
    end

    // Each burst word has a fixed slot and takes its index from the slot position.
    generate
        for (genvar i = 0; i < BURST_LEN; i++) begin : g_word
            assign hit[i]  = slot_v[LAG-1+i];
            assign cand[i] = {slot_a[LAG-1+i], IDX_W'(i)};
        end
    endgenerate

    // Merge the word windows; at most one is active.
    always_comb begin
        act       = |hit;
        word_addr = '0;
        for (int i = 0; i < BURST_LEN; i++) begin
            if (hit[i]) begin
                word_addr = word_addr | cand[i];
            end
        end
    end
endmodule

// File: rtl/qdr_b4_lane_array.sv
// Module: word storage split into byte lanes. It has one synchronous
// write port with active-low lane enables and one asynchronous read port.
// Assumes storage contents are undefined until written.
module qdr_b4_lane_array
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk2x,
    input  logic                    we,
    input  logic [ADDR_W+IDX_W-1:0] waddr,
    input  word_t                   wdata,
    input  lane_en_t                wlane_n,
    input  logic [ADDR_W+IDX_W-1:0] raddr,
    output word_t                   rdata
);
    localparam int WA_W  = ADDR_W + IDX_W;
    localparam int WORDS = 1 << WA_W;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] store [WORDS];

            // Write this lane when a word is due and its enable is low.
            always_ff @(posedge clk2x) begin
                if (we && !wlane_n[l]) begin
                    store[waddr] <= wdata[l*LANE_W +: LANE_W];
                end
            end

            assign rdata[l*LANE_W +: LANE_W] = store[raddr];
        end
    endgenerate
endmodule

// File: rtl/qdr_b4_sram.sv
// Module: top of the burst-of-four quad-data-rate SRAM model. Each
// clk2x tick is one half-cycle, and k_rise marks the K half.
// Writes take data 2 ticks after the command; reads drive data 5 ticks
// after it. Assumes k_rise alternates starting high after reset.
module qdr_b4_sram
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              k_rise,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic [WORD_W-1:0] q,
    output logic              q_valid,
    output logic              q_oe
);
    localparam int WA_W = ADDR_W + IDX_W;

    logic            rd_go;
    logic            wr_go;
    logic            rd_act;
    logic            wr_act;
    logic [WA_W-1:0] rd_waddr;
    logic [WA_W-1:0] wr_waddr;
    word_t           rd_data;

    qdr_b4_cmd_gate i_rd_gate (
        .clk2x  (clk2x),
        .rst_n  (rst_n),
        .k_rise (k_rise),
        .sel_n  (rd_sel_n),
        .go     (rd_go)
    );

    qdr_b4_cmd_gate i_wr_gate (
        .clk2x  (clk2x),
        .rst_n  (rst_n),
        .k_rise (k_rise),
        .sel_n  (wr_sel_n),
        .go     (wr_go)
    );

    qdr_b4_burst_pipe #(.ADDR_W(ADDR_W), .LAG(WR_LAG)) i_wr_pipe (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .go        (wr_go),
        .base      (addr),
        .act       (wr_act),
        .word_addr (wr_waddr)
    );

    qdr_b4_burst_pipe #(.ADDR_W(ADDR_W), .LAG(RD_LAG)) i_rd_pipe (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .go        (rd_go),
        .base      (addr),
        .act       (rd_act),
        .word_addr (rd_waddr)
    );

    qdr_b4_lane_array #(.ADDR_W(ADDR_W)) i_array (
        .clk2x   (clk2x),
        .we      (wr_act),
        .waddr   (wr_waddr),
        .wdata   (d),
        .wlane_n (lane_wr_n),
        .raddr   (rd_waddr),
        .rdata   (rd_data)
    );

    // Register the output word and its flags; idle ticks park the output at zero.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
            q_oe    <= 1'b0;
        end else if (rd_act) begin
            q       <= rd_data;
            q_valid <= 1'b1;
            q_oe    <= 1'b1;
        end else begin
            q       <= '0;
            q_valid <= 1'b0;
            q_oe    <= 1'b0;
        end
    end
endmodule

// File: rtl/qdr_b4_sram_chk.sv
// Module: assertion checker for qdr_b4_sram, bound to every instance.
// Assumes the same clock and reset as the checked instance.
module qdr_b4_sram_chk (
    input logic        clk2x,
    input logic        rst_n,
    input logic        k_rise,
    input logic        rd_go,
    input logic        wr_go,
    input logic [17:0] q,
    input logic        q_valid,
    input logic        q_oe
);
    assert_cmd_on_k_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
        (rd_go || wr_go) |-> k_rise);

    assert_rd_latency_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_go |-> ##6 q_valid);

    assert_burst_len_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(q_valid) |-> ##3 q_valid);

    assert_first_phase_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(q_valid) |-> k_rise);

    assert_rd_no_repeat_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_go |-> ##2 !rd_go);

    assert_wr_no_repeat_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_go |-> ##2 !wr_go);

    assert_idle_quiet_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
        !q_valid |-> (q == 18'd0 && !q_oe));

    assert_reset_idle_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(rst_n) |-> (!q_valid && !q_oe));
endmodule

bind qdr_b4_sram qdr_b4_sram_chk i_chk (
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .k_rise  (k_rise),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .q       (q),
    .q_valid (q_valid),
    .q_oe    (q_oe)
);

// File: tb/test_qdr_b4_sram.sv
// Bench: walks a table of K-cycle commands and keeps its own word
// scoreboard. It checks the output on every half-cycle tick, then runs
// directed reset tests.
module test_qdr_b4_sram;
    localparam int TICK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NV = 40;
    // Entry: {rd_n, wr_n, kbar_noise, tag[2:0], addr[7:0], lanes[7:0], seed[7:0]}
    localparam logic [29:0] NOP = {1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 8'h00, 8'h00};
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h10, 8'h00, 8'hA1}, NOP,
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h11, 8'h00, 8'hB2}, NOP,
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h12, 8'h00, 8'hC3}, NOP,
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h20, 8'h00, 8'hD4}, NOP,
        {1'b0, 1'b1, 1'b0, 3'd0, 8'h10, 8'h00, 8'h00},
        {1'b1, 1'b1, 1'b1, 3'd1, 8'h00, 8'h00, 8'h00},
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h13, 8'h00, 8'hE5},
        {1'b1, 1'b1, 1'b1, 3'd1, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 3'd3, 8'h10, 8'h93, 8'h6F}, NOP,
        {1'b0, 1'b1, 1'b0, 3'd3, 8'h10, 8'h00, 8'h00}, NOP,
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h11, 8'h00, 8'h77},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h11, 8'h00, 8'h88}, NOP,
        {1'b0, 1'b1, 1'b0, 3'd2, 8'h11, 8'h00, 8'h00}, NOP,
        {1'b0, 1'b1, 1'b0, 3'd2, 8'h12, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b0, 3'd2, 8'h12, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b0, 3'd0, 8'h20, 8'h00, 8'h00}, NOP, NOP,
        {1'b0, 1'b1, 1'b0, 3'd4, 8'h20, 8'h00, 8'h00}, NOP,
        {1'b1, 1'b0, 1'b0, 3'd4, 8'h20, 8'h00, 8'h99}, NOP,
        {1'b0, 1'b1, 1'b0, 3'd4, 8'h20, 8'h00, 8'h00}, NOP,
        {1'b0, 1'b0, 1'b0, 3'd4, 8'h12, 8'h00, 8'hAB}, NOP, NOP,
        {1'b0, 1'b1, 1'b0, 3'd0, 8'h13, 8'h00, 8'h00}, NOP, NOP, NOP, NOP
    };

    logic          clk2x = 1'b0;
    logic          rst_n;
    logic          k_rise;
    logic          rd_sel_n;
    logic          wr_sel_n;
    logic [AW-1:0] addr;
    logic [17:0]   d;
    logic [1:0]    lane_wr_n;
    logic [17:0]   q;
    logic          q_valid;
    logic          q_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    int  n = 0;
    bit  wtook = 1'b0;
    bit  rtook = 1'b0;

    logic [17:0]   sb [1024];
    bit            pw_v [16];
    logic [9:0]    pw_a [16];
    logic [17:0]   pw_d [16];
    logic [1:0]    pw_be [16];
    bit            pr_v [16];
    logic [9:0]    pr_a [16];
    string         pr_tag [16];

    always #(TICK_PERIOD/2) clk2x = ~clk2x;

    qdr_b4_sram #(.ADDR_W(AW)) i_qdr_b4_sram (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .k_rise    (k_rise),
        .rd_sel_n  (rd_sel_n),
        .wr_sel_n  (wr_sel_n),
        .addr      (addr),
        .d         (d),
        .lane_wr_n (lane_wr_n),
        .q         (q),
        .q_valid   (q_valid),
        .q_oe      (q_oe)
    );

    function automatic string tag_name(input logic [2:0] c);
        case (c)
            3'd0:    return "R2 R3 burst";
            3'd1:    return "R1 kbar select";
            3'd2:    return "R4 back-to-back";
            3'd3:    return "R6 R7 byte lanes";
            3'd4:    return "R9 port overlap";
            default: return "R5 idle";
        endcase
    endfunction

    task automatic check(input string tag, input bit ok, input logic [17:0] exp, input bit exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual q=%h valid=%b oe=%b expected q=%h valid=%b",
                     tag, q, q_valid, q_oe, exp, exp_v);
        end
    endtask

    task automatic clear_plans();
        for (int s = 0; s < 16; s++) begin
            pw_v[s] = 1'b0;
            pr_v[s] = 1'b0;
        end
    endtask

    // One tick: drive at the falling edge, sample at the next falling edge.
    task automatic tick(input bit is_k, input bit c_rd_n, input bit c_wr_n, input bit noise,
                        input logic [7:0] a, input logic [7:0] lanes, input logic [7:0] seed,
                        input string tag, input string itag);
        int slot = n % 16;
        k_rise = is_k;
        if (is_k) begin
            bit acc_r = !c_rd_n && !rtook;
            bit acc_w = !c_wr_n && !wtook;
            rd_sel_n = c_rd_n;
            wr_sel_n = c_wr_n;
            addr     = a;
            rtook    = acc_r;
            wtook    = acc_w;
            for (int i = 0; i < 4; i++) begin
                if (acc_w) begin
                    pw_v[(n+2+i)%16]  = 1'b1;
                    pw_a[(n+2+i)%16]  = {a, 2'(i)};
                    pw_d[(n+2+i)%16]  = {seed, 2'(i), ~seed};
                    pw_be[(n+2+i)%16] = lanes[2*i +: 2];
                end
                if (acc_r) begin
                    pr_v[(n+5+i)%16]   = 1'b1;
                    pr_a[(n+5+i)%16]   = {a, 2'(i)};
                    pr_tag[(n+5+i)%16] = tag;
                end
            end
        end else begin
            rd_sel_n = !noise;
            wr_sel_n = !noise;
            addr     = noise ? 8'hEE : a;
        end
        if (pw_v[slot]) begin
            d         = pw_d[slot];
            lane_wr_n = pw_be[slot];
        end else begin
            d         = 18'h2AAAA ^ 18'(n);
            lane_wr_n = 2'b00;
        end
        @(posedge clk2x);
        @(negedge clk2x);
        if (pr_v[slot]) begin
            logic [17:0] e = sb[pr_a[slot]];
            check(pr_tag[slot], q_valid && q_oe && q == e, e, 1'b1);
        end else begin
            check(itag, !q_valid && !q_oe && q == 18'd0, 18'd0, 1'b0);
        end
        if (pw_v[slot]) begin
            if (!pw_be[slot][0]) sb[pw_a[slot]][8:0]  = pw_d[slot][8:0];
            if (!pw_be[slot][1]) sb[pw_a[slot]][17:9] = pw_d[slot][17:9];
        end
        pw_v[slot] = 1'b0;
        pr_v[slot] = 1'b0;
        n++;
    endtask

    task automatic run_k(input logic [29:0] v, input string itag_override);
        string tag  = tag_name(v[26:24]);
        string itag = (itag_override != "") ? itag_override
                    : ((v[26:24] == 3'd1 || v[26:24] == 3'd2) ? tag : "R5 idle");
        tick(1'b1, v[29], v[28], v[27], v[23:16], v[15:8], v[7:0], tag, itag);
        tick(1'b0, v[29], v[28], v[27], v[23:16], v[15:8], v[7:0], tag, itag);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk2x);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R3: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; k_rise = 1'b1; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        addr = '0; d = '0; lane_wr_n = 2'b11;
        clear_plans();
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        // R8: quiet outputs while reset is held
        check("R8 reset", !q_valid && !q_oe && q == 18'd0, 18'd0, 1'b0);
        rst_n = 1'b1;
        n = 0;

        for (int e = 0; e < NV; e++) begin
            run_k(VEC[e], "");
        end

        // R8: a reset during a read burst cancels it
        run_k({1'b0, 1'b1, 1'b0, 3'd0, 8'h10, 8'h00, 8'h00}, "");
        run_k(NOP, "");
        rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk2x);
            @(negedge clk2x);
            check("R8 reset mid-burst", !q_valid && !q_oe && q == 18'd0, 18'd0, 1'b0);
        end
        rst_n = 1'b1;
        clear_plans();
        n = 0; rtook = 1'b0; wtook = 1'b0;
        repeat (5) run_k(NOP, "R8 after reset");
        // Traffic resumes after reset: read back a burst written before it.
        run_k({1'b0, 1'b1, 1'b0, 3'd0, 8'h11, 8'h00, 8'h00}, "R8 after reset");
        repeat (5) run_k(NOP, "R8 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule